// File: doc/BRIEF.md
# DMA Ready and Multi-Function Pin Generator

This block produces the active-low transmit-ready handshake for one serial channel and drives one programmable multi-function output pin. The transmit-ready level comes from the transmit FIFO occupancy and full flag. A receive-ready level comes from the receive FIFO occupancy, the programmed trigger level and the receive time-out flag. Two rules apply. In single-transfer mode (mode 0) each ready signal follows the presence of data or space. In block mode (mode 1) the signals wait for a full FIFO or a trigger, then hold until the FIFO drains.

Block mode is in force only when both the FIFO-enable bit and the DMA-mode bit are set. In every other case the block runs in mode 0. A two-bit function select places one of three signals on the multi-function pin: the inverted OP2 control bit, the 16x baud clock, or the receive-ready level. Every output leaves a flop clocked by the system clock. Each output therefore reflects the inputs sampled at the previous rising edge, and reset holds every output high.

Top module: `chan_ready_pins`

## Requirements
- R1: While reset is high, tx_ready_n and mf_out are both 1. After reset, the function select acts as code 00 until the first clock edge samples a new one.
- R2: In mode 0, tx_ready_n is 0 one clock after tx_count was sampled as 0. It is 1 one clock after tx_count was sampled nonzero.
- R3: In mode 1, tx_ready_n equals the tx_full flag sampled one clock earlier. It is 1 only when the FIFO is full, so any free location gives 0.
- R4: In mode 0, the receive-ready level is 0 one clock after rx_count was sampled nonzero, and 1 otherwise.
- R5: In mode 1, the receive-ready level goes to 0 one clock after a nonzero rx_count that is at or above rx_trig_level, or one that comes with rx_timeout=1. It then stays 0 while rx_count stays nonzero, even below the trigger.
- R6: In mode 1, the receive-ready level goes to 1 one clock after rx_count was sampled as 0. This holds even when rx_timeout is 1. The level stays 1 below the trigger when no time-out is present.
- R7: Mode 1 applies only when fifo_en=1 and dma_mode=1. With fifo_en=0, dma_mode=1 gives mode-0 behaviour on both ready signals.
- R8: With mf_sel code 00 or 11, mf_out is the inverse of op2_ctl sampled one clock earlier.
- R9: With mf_sel code 01, mf_out equals baud16_clk sampled one clock earlier.
- R10: With mf_sel code 10, mf_out carries the receive-ready level of R4 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| tx_full | input | 1 | Transmit FIFO full flag |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_trig_level | input | CNT_W | Receive trigger level in characters |
| rx_timeout | input | 1 | Receive time-out flag |
| fifo_en | input | 1 | FIFO enable bit |
| dma_mode | input | 1 | DMA mode bit, 1 = block mode |
| baud16_clk | input | 1 | 16x baud clock level |
| op2_ctl | input | 1 | OP2 control bit |
| mf_sel | input | 2 | Multi-function pin select (00 OP2, 01 baud, 10 receive ready, 11 OP2) |
| tx_ready_n | output | 1 | Transmit ready, active low |
| mf_out | output | 1 | Multi-function output pin |

## Verification
A wrong receive-ready state is visible only while the pin selects receive ready. It shows one clock after rx_count falls below the trigger, when mode 1 must hold the level low, or one clock after the count reaches zero, when the level must rise. A wrong mode decode shows on tx_ready_n one clock after a nonzero count arrives with the full flag clear. Mode 0 then drives the pin high and mode 1 drives it low. The stimulus walks rx_count across the trigger in both directions so that the held state is exposed.

// File: rtl/chan_rdy_pkg.sv
package chan_rdy_pkg;

  typedef enum logic [1:0] {
    MF_OP2     = 2'b00,
    MF_BAUD    = 2'b01,
    MF_RXRDY   = 2'b10,
    MF_OP2_ALT = 2'b11
  } mf_func_e;

  // transmit ready level, active low
  function automatic logic tx_ready_lvl(input logic blk, input int unsigned cnt,
                                        input logic full);
    if (blk) return full;
    return (cnt != 0);
  endfunction

  // next receive ready level, active low; cur is the held level
  function automatic logic rx_ready_nxt(input logic blk, input int unsigned cnt,
                                        input int unsigned trig, input logic tout,
                                        input logic cur);
    if (cnt == 0) return 1'b1;
    if (!blk) return 1'b0;
    if ((cnt >= trig) || tout) return 1'b0;
    return cur;
  endfunction

  // level for the non-receive functions of the shared pin
  function automatic logic mf_local(input mf_func_e f, input logic op2, input logic baud);
    if (f == MF_BAUD) return baud;
    return ~op2;
  endfunction

endpackage

// File: rtl/tx_ready_gen.sv
module tx_ready_gen #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_mode,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             tx_full,
  output logic             tx_ready_n
);
  import chan_rdy_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) tx_ready_n <= 1'b1;
    else     tx_ready_n <= tx_ready_lvl(blk_mode, 32'(tx_count), tx_full);
  end
endmodule

// File: rtl/rx_ready_gen.sv
module rx_ready_gen #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_mode,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig_level,
  input  logic             rx_timeout,
  output logic             rx_ready_n
);
  import chan_rdy_pkg::*;

  logic nxt_n;

  always_comb
    nxt_n = rx_ready_nxt(blk_mode, 32'(rx_count), 32'(rx_trig_level), rx_timeout, rx_ready_n);

  always_ff @(posedge clk) begin
    if (rst) rx_ready_n <= 1'b1;
    else     rx_ready_n <= nxt_n;
  end
endmodule

// File: rtl/mf_out_sel.sv
module mf_out_sel (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mf_sel,
  input  logic       op2_ctl,
  input  logic       baud16_clk,
  input  logic       rx_ready_n,
  output logic       mf_out
);
  import chan_rdy_pkg::*;

  mf_func_e sel_q;
  logic     loc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= MF_OP2;
      loc_q <= 1'b1;
    end else begin
      sel_q <= mf_func_e'(mf_sel);
      loc_q <= mf_local(mf_func_e'(mf_sel), op2_ctl, baud16_clk);
    end
  end

  // both legs come from flops, so the pin follows the sampled inputs
  always_comb mf_out = (sel_q == MF_RXRDY) ? rx_ready_n : loc_q;
endmodule

// File: rtl/chan_ready_pins.sv
module chan_ready_pins #(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             tx_full,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig_level,
  input  logic             rx_timeout,
  input  logic             fifo_en,
  input  logic             dma_mode,
  input  logic             baud16_clk,
  input  logic             op2_ctl,
  input  logic [1:0]       mf_sel,
  output logic             tx_ready_n,
  output logic             mf_out
);

  logic blk_mode;      // block transfer mode in force
  logic rx_ready_n_w;  // receive ready level, active low

  assign blk_mode = fifo_en & dma_mode;

  tx_ready_gen #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .blk_mode(blk_mode),
    .tx_count(tx_count), .tx_full(tx_full), .tx_ready_n(tx_ready_n)
  );

  rx_ready_gen #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .blk_mode(blk_mode),
    .rx_count(rx_count), .rx_trig_level(rx_trig_level),
    .rx_timeout(rx_timeout), .rx_ready_n(rx_ready_n_w)
  );

  mf_out_sel u_mf (
    .clk(clk), .rst(rst), .mf_sel(mf_sel), .op2_ctl(op2_ctl),
    .baud16_clk(baud16_clk), .rx_ready_n(rx_ready_n_w), .mf_out(mf_out)
  );
endmodule

// File: rtl/chan_ready_pins_chk.sv
module chan_ready_pins_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] tx_count,
  input logic             tx_full,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] rx_trig_level,
  input logic             rx_timeout,
  input logic             fifo_en,
  input logic             dma_mode,
  input logic             baud16_clk,
  input logic             op2_ctl,
  input logic [1:0]       mf_sel,
  input logic             tx_ready_n,
  input logic             mf_out,
  input logic             rx_ready_n_w
);
  logic blk;
  assign blk = fifo_en && dma_mode;

  assert_reset_high_R1: assert property (@(posedge clk)
    rst |=> (tx_ready_n && mf_out));

  assert_tx_single_R2: assert property (@(posedge clk) disable iff (rst)
    !blk |=> (tx_ready_n == ($past(tx_count) != 0)));

  assert_tx_block_R3: assert property (@(posedge clk) disable iff (rst)
    blk |=> (tx_ready_n == $past(tx_full)));

  assert_rx_single_R4: assert property (@(posedge clk) disable iff (rst)
    !blk |=> (rx_ready_n_w == ($past(rx_count) == 0)));

  assert_rx_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (blk && rx_count != 0 && (rx_count >= rx_trig_level || rx_timeout)) |=> !rx_ready_n_w);

  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (blk && rx_count != 0 && rx_count < rx_trig_level && !rx_timeout)
      |=> (rx_ready_n_w == $past(rx_ready_n_w)));

  assert_rx_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_count == 0) |=> rx_ready_n_w);

  assert_mf_op2_R8: assert property (@(posedge clk) disable iff (rst)
    (mf_sel == 2'b00 || mf_sel == 2'b11) |=> (mf_out == !$past(op2_ctl)));

  assert_mf_baud_R9: assert property (@(posedge clk) disable iff (rst)
    (mf_sel == 2'b01) |=> (mf_out == $past(baud16_clk)));

  assert_mf_rx_R10: assert property (@(posedge clk) disable iff (rst)
    (mf_sel == 2'b10) |=> (mf_out == rx_ready_n_w));
endmodule

bind chan_ready_pins chan_ready_pins_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tx_count(tx_count), .tx_full(tx_full),
  .rx_count(rx_count), .rx_trig_level(rx_trig_level), .rx_timeout(rx_timeout),
  .fifo_en(fifo_en), .dma_mode(dma_mode), .baud16_clk(baud16_clk),
  .op2_ctl(op2_ctl), .mf_sel(mf_sel), .tx_ready_n(tx_ready_n),
  .mf_out(mf_out), .rx_ready_n_w(rx_ready_n_w)
);

// File: tb/chan_ready_pins_bench.sv
module chan_ready_pins_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] tx_count = '0, rx_count = '0, rx_trig_level = CW'(1);
  logic tx_full = 0, rx_timeout = 0, fifo_en = 0, dma_mode = 0;
  logic baud16_clk = 0, op2_ctl = 1;
  logic [1:0] mf_sel = 2'b00;
  logic tx_ready_n, mf_out;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct {
    logic  e_tx;
    logic  e_mf;
    bit    c_tx;
    bit    c_mf;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_ready_pins #(.FIFO_DEPTH(DEPTH)) u_chan_ready_pins (
    .clk(clk), .rst(rst), .tx_count(tx_count), .tx_full(tx_full),
    .rx_count(rx_count), .rx_trig_level(rx_trig_level), .rx_timeout(rx_timeout),
    .fifo_en(fifo_en), .dma_mode(dma_mode), .baud16_clk(baud16_clk),
    .op2_ctl(op2_ctl), .mf_sel(mf_sel), .tx_ready_n(tx_ready_n), .mf_out(mf_out)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: each item is due one edge after its stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        if (it.c_tx) check({it.tag, " tx_ready_n"}, tx_ready_n, it.e_tx);
        if (it.c_mf) check({it.tag, " mf_out"}, mf_out, it.e_mf);
      end
    end
  end

  task automatic push(input logic etx, input logic emf, input bit ctx, input bit cmf,
                      input string tag);
    exp_t it;
    it.e_tx = etx; it.e_mf = emf; it.c_tx = ctx; it.c_mf = cmf; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic tx_step(input int cnt, input logic full, input logic fe, input logic dm,
                         input logic exp, input string tag);
    @(negedge clk);
    tx_count = CW'(cnt); tx_full = full; fifo_en = fe; dma_mode = dm;
    push(exp, 1'b0, 1, 0, tag);
  endtask

  task automatic rx_step(input int cnt, input int trig, input logic tout, input logic fe,
                         input logic dm, input logic exp, input string tag);
    @(negedge clk);
    mf_sel = 2'b10; rx_count = CW'(cnt); rx_trig_level = CW'(trig);
    rx_timeout = tout; fifo_en = fe; dma_mode = dm;
    push(1'b0, exp, 0, 1, tag);
  endtask

  task automatic mf_step(input logic [1:0] sel, input logic op2, input logic bd,
                         input logic exp, input string tag);
    @(negedge clk);
    mf_sel = sel; op2_ctl = op2; baud16_clk = bd;
    push(1'b0, exp, 0, 1, tag);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<=5000 cycles", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R1: op2_ctl=1 would drive the pin low if the reset value were not forced
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset tx_ready_n", tx_ready_n, 1'b1);
    check("R1 reset mf_out", mf_out, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    push(1'b0, 1'b0, 1, 1, "R1 first edge");

    // R2: single-transfer transmit
    tx_step(1, 0, 0, 0, 1'b1, "R2 one char, fifos off");
    tx_step(0, 0, 0, 0, 1'b0, "R2 empty, fifos off");
    tx_step(5, 0, 1, 0, 1'b1, "R2 five chars, mode 0");
    tx_step(0, 0, 1, 0, 1'b0, "R2 empty, mode 0");
    // R7: dma bit without fifo enable stays in mode 0
    tx_step(1, 0, 0, 1, 1'b1, "R7 tx dma without fifo");
    // R3: block transmit
    tx_step(5, 0, 1, 1, 1'b0, "R3 space free");
    tx_step(15, 0, 1, 1, 1'b0, "R3 one slot free");
    tx_step(16, 1, 1, 1, 1'b1, "R3 full");
    tx_step(0, 0, 1, 1, 1'b0, "R3 drained");

    // R4 and R10: single-transfer receive on the shared pin
    rx_step(0, 4, 0, 1, 0, 1'b1, "R4 empty");
    rx_step(1, 4, 0, 1, 0, 1'b0, "R4 one char below trigger");
    rx_step(3, 4, 0, 1, 0, 1'b0, "R10 three chars");
    rx_step(0, 4, 0, 1, 0, 1'b1, "R4 drained");
    // R5 and R6: block receive, trigger 4
    rx_step(2, 4, 0, 1, 1, 1'b1, "R6 below trigger");
    rx_step(4, 4, 0, 1, 1, 1'b0, "R5 trigger reached");
    rx_step(2, 4, 0, 1, 1, 1'b0, "R5 held below trigger");
    rx_step(0, 4, 0, 1, 1, 1'b1, "R6 empty releases");
    rx_step(1, 4, 1, 1, 1, 1'b0, "R5 time-out");
    rx_step(1, 4, 0, 1, 1, 1'b0, "R5 held after time-out");
    rx_step(0, 4, 1, 1, 1, 1'b1, "R6 empty with time-out");
    rx_step(8, 4, 0, 1, 1, 1'b0, "R5 above trigger");
    rx_step(0, 4, 0, 0, 1, 1'b1, "R7 rx empty, dma without fifo");
    rx_step(1, 4, 0, 0, 1, 1'b0, "R7 rx one char, dma without fifo");

    // R8 and R9: other pin functions
    mf_step(2'b00, 1, 0, 1'b0, "R8 op2 set");
    mf_step(2'b00, 0, 0, 1'b1, "R8 op2 clear");
    mf_step(2'b11, 1, 0, 1'b0, "R8 code 11 op2 set");
    mf_step(2'b11, 0, 1, 1'b1, "R8 code 11 ignores baud");
    mf_step(2'b01, 1, 1, 1'b1, "R9 baud high");
    mf_step(2'b01, 1, 0, 1'b0, "R9 baud low");
    mf_step(2'b01, 0, 1, 1'b1, "R9 baud high again");

    repeat (3) @(posedge clk);
    #2;
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sb_q.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule